// File: doc/BRIEF.md
# Parallel Camera Capture Sequencer

This block takes the output of an 8-bit parallel image sensor: a frame sync, a line-valid level, a pixel clock and a byte bus. It brings it into the system clock domain and tracks the video timing with a three-state sequencer. The three states are waiting for a frame, waiting for a line, and inside a line. Each state change comes from one particular sync edge. Inside a line, every pixel-clock rising edge captures one byte and emits a one-cycle transfer request. The downstream mover can then move bytes without software involvement.

Pixels are RGB565 and arrive as two bytes, high byte first. The block joins each pair into a 16-bit word and strobes it out with a pixel-valid pulse. A pulse at every frame start lets the consumer re-arm its transfer for the first line. A pulse at every line end re-arms it for the next line.

The block also reports the pixel count of the current or last line and the number of lines completed in the current frame. A sticky flag records any line whose length was wrong. The default line length is 320 pixels for a 320x240 frame. The sensor pins are asynchronous. The system clock must run at least four times faster than the pixel clock.

Top module: `cam_capture_seq`

## Requirements
- R1: After reset, state_o is 0 (waiting for a frame), all pulse outputs are 0, both counters are 0 and err_o is 0.
- R2: A rising edge of vsync_i moves state_o to 0 from any state. It gives exactly one frame_arm_o pulse and clears line_cnt_o to 0.
- R3: A falling edge of vsync_i, or a falling edge of href_i, moves state_o to 1 (waiting for a line). A vsync_i rising edge has priority over both.
- R4: A rising edge of href_i while state_o is 1 moves state_o to 2 (inside a line). A rising edge of href_i while state_o is 0 is ignored.
- R5: While state_o is 2, each rising edge of pclk_i gives exactly one xfer_req_o pulse. In any other state, pclk_i edges give none.
- R6: Within a line, bytes alternate high then low. The byte phase restarts at the high byte at every line start. On each second byte, pix_valid_o pulses together with xfer_req_o, and pix_data_o carries {high byte, low byte}.
- R7: Each falling edge of href_i while state_o is 2 gives exactly one line_arm_o pulse and increments line_cnt_o.
- R8: pix_cnt_o is cleared at line start and counts the completed pixels of the line. It holds its value after the line ends, until the next line start.
- R9: err_o becomes 1 when a line ends with a pixel count other than LINE_PIX or with an unpaired high byte. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Sensor frame sync, asynchronous |
| href_i | input | 1 | Sensor line-valid level, asynchronous |
| pclk_i | input | 1 | Sensor pixel clock, sampled as data |
| data_i | input | 8 | Sensor byte bus |
| state_o | output | 2 | Sequencer state: 0 wait frame, 1 wait line, 2 in line |
| xfer_req_o | output | 1 | One-cycle request per captured byte |
| pix_valid_o | output | 1 | Strobe for an assembled pixel |
| pix_data_o | output | 16 | Assembled RGB565 pixel, high byte in [15:8] |
| frame_arm_o | output | 1 | Frame-start re-arm pulse |
| line_arm_o | output | 1 | Line-end re-arm pulse |
| pix_cnt_o | output | PIX_W | Pixels in current/last line, saturating |
| line_cnt_o | output | LINE_W | Lines completed in current frame, saturating |
| err_o | output | 1 | Sticky line-format error |

## Verification
Full lines of random bytes check byte pairing, pixel order and the per-byte request count against words the bench assembles itself. Lines that are one byte odd, one pixel short or one pixel long each set the sticky flag. A correct line that follows shows that the flag does not clear itself. Href pulses and pixel clocks sent while frame sync is high must leave the sequencer waiting for a frame, with no requests. A frame sync raised in the middle of a line shows the priority of the frame edge and the clearing of the line count.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_FRAME = 2'd0,
    ST_WAIT_LINE  = 2'd1,
    ST_IN_LINE    = 2'd2
  } seq_st_e;
endpackage

// File: rtl/cam_edge_sync.sv
module cam_edge_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES:0] chain_q;  // STAGES sync flops plus one history flop
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], async_i[b]};
    end
    assign rise_o[b] =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[b] = ~chain_q[STAGES-1] &  chain_q[STAGES];
  end
endmodule

// File: rtl/cam_seq_fsm.sv
module cam_seq_fsm
  import cam_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    vs_rise_i,
  input  logic    vs_fall_i,
  input  logic    hr_rise_i,
  input  logic    hr_fall_i,
  input  logic    pc_rise_i,
  output seq_st_e state_o,
  output logic    line_start_o,
  output logic    line_end_o,
  output logic    byte_stb_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (vs_rise_i)                           st_d = ST_WAIT_FRAME;
    else if (vs_fall_i || hr_fall_i)         st_d = ST_WAIT_LINE;
    else if (hr_rise_i && st_q == ST_WAIT_LINE) st_d = ST_IN_LINE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_WAIT_FRAME;
    else         st_q <= st_d;
  end

  assign state_o      = st_q;
  assign line_start_o = hr_rise_i && st_q == ST_WAIT_LINE && !vs_rise_i && !vs_fall_i;
  assign line_end_o   = hr_fall_i && st_q == ST_IN_LINE;
  assign byte_stb_o   = pc_rise_i && st_q == ST_IN_LINE;

  a_r2_frame_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_rise_i |=> st_q == ST_WAIT_FRAME);
  a_r4_href_ignored_in_frame_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_FRAME && !vs_fall_i && !hr_fall_i) |=> st_q != ST_IN_LINE);
  a_r3_legal_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != 2'd3);
endmodule

// File: rtl/cam_line_acc.sv
module cam_line_acc #(
  parameter int LINE_PIX    = 320,
  parameter int FRAME_LINES = 240,
  parameter int PIX_W       = $clog2(LINE_PIX + 2),
  parameter int LINE_W      = $clog2(FRAME_LINES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              line_start_i,
  input  logic              line_end_i,
  input  logic              byte_stb_i,
  input  logic [7:0]        byte_i,
  output logic              pix_valid_o,
  output logic [15:0]       pix_data_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              err_o
);
  logic              phase_q;   // 1: high byte held, waiting for low byte
  logic [7:0]        hi_q;
  logic [PIX_W-1:0]  pix_cnt_q;
  logic [LINE_W-1:0] line_cnt_q;
  logic              err_q;
  logic              bad_line;

  assign bad_line = phase_q || (pix_cnt_q != PIX_W'(LINE_PIX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      hi_q        <= '0;
      pix_cnt_q   <= '0;
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
    end else begin
      pix_valid_o <= 1'b0;
      if (line_start_i) begin
        phase_q   <= 1'b0;
        pix_cnt_q <= '0;
      end else if (byte_stb_i) begin
        phase_q <= ~phase_q;
        if (!phase_q) begin
          hi_q <= byte_i;
        end else begin
          pix_data_o  <= {hi_q, byte_i};
          pix_valid_o <= 1'b1;
          if (pix_cnt_q != '1) pix_cnt_q <= pix_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_cnt_q <= '0;
      err_q      <= 1'b0;
    end else begin
      if (frame_start_i)                        line_cnt_q <= '0;
      else if (line_end_i && line_cnt_q != '1)  line_cnt_q <= line_cnt_q + 1'b1;
      if (line_end_i && bad_line)               err_q <= 1'b1;
    end
  end

  assign pix_cnt_o  = pix_cnt_q;
  assign line_cnt_o = line_cnt_q;
  assign err_o      = err_q;

  a_r6_pair_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> !phase_q);
  a_r8_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> pix_cnt_q == '0 && !phase_q);
endmodule

// File: rtl/cam_capture_seq.sv
module cam_capture_seq
  import cam_pkg::*;
#(
  parameter int LINE_PIX    = 320,
  parameter int FRAME_LINES = 240,
  parameter int SYNC_STAGES = 2,
  localparam int PIX_W      = $clog2(LINE_PIX + 2),
  localparam int LINE_W     = $clog2(FRAME_LINES + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              href_i,
  input  logic              pclk_i,
  input  logic [7:0]        data_i,
  output logic [1:0]        state_o,
  output logic              xfer_req_o,
  output logic              pix_valid_o,
  output logic [15:0]       pix_data_o,
  output logic              frame_arm_o,
  output logic              line_arm_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              err_o
);
  logic [2:0] rise, fall;
  logic [7:0] data_dly [SYNC_STAGES];
  seq_st_e    st;
  logic       line_start, line_end, byte_stb;

  cam_edge_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i ({pclk_i, href_i, vsync_i}),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  // Byte bus delayed to line up with the pixel-clock edge detector.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC_STAGES; i++) data_dly[i] <= '0;
    end else begin
      data_dly[0] <= data_i;
      for (int i = 1; i < SYNC_STAGES; i++) data_dly[i] <= data_dly[i-1];
    end
  end

  cam_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .vs_rise_i    (rise[0]),
    .vs_fall_i    (fall[0]),
    .hr_rise_i    (rise[1]),
    .hr_fall_i    (fall[1]),
    .pc_rise_i    (rise[2]),
    .state_o      (st),
    .line_start_o (line_start),
    .line_end_o   (line_end),
    .byte_stb_o   (byte_stb)
  );

  cam_line_acc #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_acc (
    .clk_i, .rst_ni,
    .frame_start_i (rise[0]),
    .line_start_i  (line_start),
    .line_end_i    (line_end),
    .byte_stb_i    (byte_stb),
    .byte_i        (data_dly[SYNC_STAGES-1]),
    .pix_valid_o,
    .pix_data_o,
    .pix_cnt_o,
    .line_cnt_o,
    .err_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xfer_req_o  <= 1'b0;
      frame_arm_o <= 1'b0;
      line_arm_o  <= 1'b0;
    end else begin
      xfer_req_o  <= byte_stb;
      frame_arm_o <= rise[0];
      line_arm_o  <= line_end;
    end
  end

  assign state_o = st;

  a_r5_req_only_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> $past(st == ST_IN_LINE));
  a_r6_valid_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> xfer_req_o);
  a_r2_arm_clears_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_arm_o |-> line_cnt_o == '0);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r7_line_arm_leaves_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_arm_o |-> st != ST_IN_LINE);
endmodule

// File: tb/cam_capture_seq_tb_top.sv
`timescale 1ns/1ps
module cam_capture_seq_tb_top;
  localparam int LP     = 8;
  localparam int FL     = 4;
  localparam int PIX_W  = $clog2(LP + 2);
  localparam int LINE_W = $clog2(FL + 2);
  localparam int HALF   = 25;  // pixel clock half period, 5 system clocks

  logic clk = 1'b0, rst_ni = 1'b0;
  logic vsync = 1'b0, href = 1'b0, pclk = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] state;
  logic xfer_req, pix_valid, frame_arm, line_arm, err;
  logic [15:0] pix_data;
  logic [PIX_W-1:0] pix_cnt;
  logic [LINE_W-1:0] line_cnt;

  int n_chk = 0, n_bad = 0;
  int c_req = 0, c_farm = 0, c_larm = 0;
  logic [15:0] exp_q[$];
  logic [7:0] hi_b;
  bit done = 0;

  always #2.5 clk = ~clk;

  cam_capture_seq #(.LINE_PIX(LP), .FRAME_LINES(FL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vsync), .href_i(href), .pclk_i(pclk),
    .data_i(data), .state_o(state), .xfer_req_o(xfer_req), .pix_valid_o(pix_valid),
    .pix_data_o(pix_data), .frame_arm_o(frame_arm), .line_arm_o(line_arm),
    .pix_cnt_o(pix_cnt), .line_cnt_o(line_cnt), .err_o(err)
  );

  function automatic logic [15:0] join_pix(logic [7:0] h, logic [7:0] l);
    return {h, l};
  endfunction

  function automatic bit exp_bad(int nbytes);
    return (nbytes % 2 != 0) || (nbytes / 2 != LP);
  endfunction

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // R6: pixel words against bench-assembled words
  always @(negedge clk) begin
    if (rst_ni) begin
      if (xfer_req)  c_req++;
      if (frame_arm) c_farm++;
      if (line_arm)  c_larm++;
      if (pix_valid) begin
        if (exp_q.size() == 0) chk("R6 unexpected pixel", 1'b0, pix_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk("R6 pixel word", pix_data == e, pix_data, e);
          chk("R6 valid with req", xfer_req, xfer_req, 1);
        end
      end
    end
  end

  task automatic clr_cnt();
    c_req = 0; c_farm = 0; c_larm = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; vsync = 0; href = 0; pclk = 0; data = '0;
    #50; rst_ni = 1'b1; #50;
    exp_q.delete(); clr_cnt();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit idx_odd, input bit track);
    pclk = 1'b0; data = b;
    if (track) begin
      if (!idx_odd) hi_b = b;
      else exp_q.push_back(join_pix(hi_b, b));
    end
    #HALF; pclk = 1'b1; #HALF;
  endtask

  task automatic frame_start();
    vsync = 1'b1; #100; vsync = 1'b0; #100;
  endtask

  task automatic send_line(input int nbytes);
    href = 1'b1; #(2*HALF);
    for (int i = 0; i < nbytes; i++) send_byte(8'($urandom()), i[0], 1'b1);
    pclk = 1'b0; #HALF; href = 1'b0; #100;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5c));
    #1;
    do_reset();
    // R1
    chk("R1 state", state == 2'd0, state, 0);
    chk("R1 err", err == 0, err, 0);
    chk("R1 counters", pix_cnt == 0 && line_cnt == 0, pix_cnt, 0);
    chk("R1 pulses", c_req == 0 && c_farm == 0 && c_larm == 0, c_req + c_farm + c_larm, 0);

    // R2/R4/R5: href and pclk during frame sync are ignored
    vsync = 1'b1; #100;
    chk("R2 frame arm pulse", c_farm == 1, c_farm, 1);
    chk("R2 state wait frame", state == 2'd0, state, 0);
    href = 1'b1; #100;
    chk("R4 href rise ignored in wait frame", state == 2'd0, state, 0);
    send_byte(8'h5a, 0, 0); send_byte(8'ha5, 1, 0);
    chk("R5 no req outside line", c_req == 0, c_req, 0);
    href = 1'b0; #100;
    chk("R3 href fall to wait line", state == 2'd1, state, 1);
    chk("R7 no line arm outside line", c_larm == 0, c_larm, 0);
    vsync = 1'b0; #100;
    chk("R3 vsync fall to wait line", state == 2'd1, state, 1);

    // Full random lines
    do_reset(); frame_start();
    chk("R3 after frame sync", state == 2'd1, state, 1);
    for (int ln = 0; ln < 3; ln++) begin
      clr_cnt();
      href = 1'b1; #100;
      chk("R4 in line", state == 2'd2, state, 2);
      chk("R8 count cleared at start", pix_cnt == 0, pix_cnt, 0);
      for (int i = 0; i < 2*LP; i++) send_byte(8'($urandom()), i[0], 1'b1);
      pclk = 1'b0; #HALF; href = 1'b0; #100;
      chk("R5 req count", c_req == 2*LP, c_req, 2*LP);
      chk("R7 line arm", c_larm == 1, c_larm, 1);
      chk("R7 line count", line_cnt == ln + 1, line_cnt, ln + 1);
      chk("R8 pixel count held", pix_cnt == LP, pix_cnt, LP);
      chk("R3 back to wait line", state == 2'd1, state, 1);
      chk("R9 good line no err", err == exp_bad(2*LP), err, exp_bad(2*LP));
    end
    chk("R6 all pixels seen", exp_q.size() == 0, exp_q.size(), 0);

    // R2: frame sync mid-line
    clr_cnt();
    href = 1'b1; #100;
    for (int i = 0; i < 3; i++) send_byte(8'($urandom()), i[0], 1'b1);
    pclk = 1'b0; vsync = 1'b1; #100;
    chk("R2 vsync rise mid line", state == 2'd0, state, 0);
    chk("R2 line count cleared", line_cnt == 0, line_cnt, 0);
    chk("R2 one frame arm", c_farm == 1, c_farm, 1);
    href = 1'b0; #100; vsync = 1'b0; #100;
    chk("R7 no arm after abort", c_larm == 0, c_larm, 0);
    chk("R6 aborted line pixel seen", exp_q.size() == 0, exp_q.size(), 0);

    // R6/R9: odd byte line, then a good line keeps err
    do_reset(); frame_start();
    send_line(2*LP + 1);
    chk("R9 odd byte line err", err == exp_bad(2*LP + 1), err, 1);
    send_line(2*LP);
    chk("R9 err sticky", err == 1, err, 1);
    chk("R6 phase restart gives full line", pix_cnt == LP, pix_cnt, LP);

    // R9: short and long lines
    do_reset(); frame_start();
    send_line(2*(LP - 1));
    chk("R9 short line err", err == exp_bad(2*(LP - 1)), err, 1);
    chk("R8 short count", pix_cnt == LP - 1, pix_cnt, LP - 1);
    do_reset(); frame_start();
    send_line(2*(LP + 1));
    chk("R9 long line err", err == exp_bad(2*(LP + 1)), err, 1);

    // Random lengths
    for (int k = 0; k < 6; k++) begin
      int nb;
      nb = 2*LP - 2 + int'($urandom_range(0, 4));
      do_reset(); frame_start();
      send_line(nb);
      chk("R9 random length", err == exp_bad(nb), err, exp_bad(nb));
      chk("R5 random req count", c_req == nb, c_req, nb);
    end
    chk("R6 queue drained", exp_q.size() == 0, exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule